// File: doc/BRIEF.md
# BCD Timekeeper Register Counter

This block keeps calendar time in a bank of eight byte-wide registers held in packed BCD: seconds, minutes, hours, day of week, date, month and year. A one-cycle `secTick` pulse advances the time by one second. The carries ripple through every field, with month lengths and leap years taken into account. A byte-wide port with an 11-bit address and separate read and write strobes gives access to the whole bank.

Several control bits share bytes with the time fields. A halt bit sits in the top bit of seconds, a start-up kick bit in hours and a test-mode bit in day of week. One further byte holds a 5-bit calibration magnitude, its sign and two access flags. All of these bits are driven out on ports, so the neighbouring oscillator, divider and calibration logic can use them.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the bank reads control 00h, seconds 80h (halt set), minutes 00h, hours 00h, day 01h, date 01h, month 01h and year 00h, and `stopOut` is 1.
- R2: Addresses 7F8h to 7FFh select control, seconds, minutes, hours, day, date, month and year in that order. `rdData` shows the selected byte one cycle after a cycle with `rdEn` high and holds it otherwise. Any other address reads 00h, and a write to it changes no register.
- R3: Bits with no function read 0 whatever is written: minutes bit 7, hours bit 6, day bits 7 and 5:3, date bits 7:6, month bits 7:5.
- R4: While seconds bit 7 (halt) is 1, ticks change no register. While it is 0, each tick advances the seconds field by one in BCD.
- R5: Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. Hours 23 wraps to 00 and carries into both day of week and date.
- R6: Day of week counts 01 to 07 and wraps from 07 to 01.
- R7: Date wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in other months (except February), and carries into month. Month 12 wraps to 01 and carries into year. Year 99 wraps to 00.
- R8: In February, date wraps after 29 when the BCD year is a multiple of four (00 included) and after 28 otherwise.
- R9: A write in the same cycle as an effective tick stores the written byte in the addressed register. No carry enters or leaves that register in that cycle; the other registers advance normally.
- R10: One cycle after a write, the outputs follow the stored bits: `calValue` = control[4:0], `calSign` = control[5], `ctlRead` = control[6], `ctlWrite` = control[7], `stopOut` = seconds[7], `kickStart` = hours[7], `freqTest` = day[6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| secTick | input | 1 | One-second advance pulse, one cycle wide |
| addr | input | 11 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| stopOut | output | 1 | Halt bit from seconds |
| kickStart | output | 1 | Kick bit from hours |
| freqTest | output | 1 | Test-mode bit from day |
| calValue | output | 5 | Calibration magnitude |
| calSign | output | 1 | Calibration sign, 1 = speed up |
| ctlRead | output | 1 | Read flag from control |
| ctlWrite | output | 1 | Write flag from control |

## Verification
Every register update, whether from a write or a tick, becomes visible at the first clock edge after the stimulus cycle. Read data arrives on `rdData` exactly one edge after the cycle in which `rdEn` was sampled. The bench drives on falling edges. A read driver pushes the expected byte into a queue, and a monitor pops it at the falling edge that follows the sampling rising edge. The static control outputs are compared at the falling edge after the write that set them, so every result is sampled half a cycle after it is due.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int REG_NUM = 8;
  localparam int IDX_W   = $clog2(REG_NUM);

  localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_SEC   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MIN   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_HOUR  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_DAY   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DATE  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MONTH = 3'd6;
  localparam logic [IDX_W-1:0] IDX_YEAR  = 3'd7;

  typedef struct packed {
    logic [REG_NUM-1:0] wrSel;
    logic               rdReq;
    logic               rdHit;
    logic [IDX_W-1:0]   rdIdx;
    logic               tickGo;
  } tkStrobe_t;

  function automatic logic [7:0] fieldMask(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_MIN:   return 8'h7F;
      IDX_HOUR:  return 8'hBF;
      IDX_DAY:   return 8'h47;
      IDX_DATE:  return 8'h3F;
      IDX_MONTH: return 8'h1F;
      default:   return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] resetVal(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_SEC:   return 8'h80;
      IDX_DAY:   return 8'h01;
      IDX_DATE:  return 8'h01;
      IDX_MONTH: return 8'h01;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [5:0] lastDate(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02: return isLeap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default: return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/tk_ctrl.sv
module tk_ctrl
  import tk_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 11'h7F8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              secTick,
  input  logic              stopBit,
  output tkStrobe_t         strb
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic             bankHit;
  logic [IDX_W-1:0] regIdx;

  always_comb begin
    bankHit     = addr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W];
    regIdx      = addr[IDX_W-1:0];
    strb.wrSel  = (wrEn && bankHit) ? (REG_NUM'(1) << regIdx) : '0;
    strb.rdReq  = rdEn;
    strb.rdHit  = bankHit;
    strb.rdIdx  = regIdx;
    strb.tickGo = secTick && !stopBit;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrSel)); // R2

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || addr[ADDR_W-1:IDX_W] != BASE_ADDR[ADDR_W-1:IDX_W]) |-> (strb.wrSel == '0)); // R2

  logic [TAG_W-1:0] unusedTag;
  assign unusedTag = '0;
endmodule

// File: rtl/tk_datapath.sv
module tk_datapath
  import tk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tkStrobe_t  strb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [7:0] ctrlByte,
  output logic       stopBit,
  output logic       kickBit,
  output logic       testBit
);
  logic [REG_NUM-1:0][7:0] regFile;
  logic [REG_NUM-1:0][7:0] nextVal;
  logic [REG_NUM-1:0]      advEn;
  logic [IDX_W-1:0]        rdIdxQ;

  logic       secWrap, minWrap, hourWrap, dayWrap, dateWrap, monWrap, yearWrap;
  logic [7:0] secInc, minInc, hourInc, dateInc, monInc, yearInc;
  logic [5:0] dateLimit;

  always_comb begin
    secInc   = bcdInc({1'b0, regFile[IDX_SEC][6:0]});
    minInc   = bcdInc({1'b0, regFile[IDX_MIN][6:0]});
    hourInc  = bcdInc({2'b0, regFile[IDX_HOUR][5:0]});
    dateInc  = bcdInc({2'b0, regFile[IDX_DATE][5:0]});
    monInc   = bcdInc({3'b0, regFile[IDX_MONTH][4:0]});
    yearInc  = bcdInc(regFile[IDX_YEAR]);
    dateLimit = lastDate(regFile[IDX_MONTH][4:0], regFile[IDX_YEAR]);

    secWrap  = regFile[IDX_SEC][6:0]   >= 7'h59;
    minWrap  = regFile[IDX_MIN][6:0]   >= 7'h59;
    hourWrap = regFile[IDX_HOUR][5:0]  >= 6'h23;
    dayWrap  = regFile[IDX_DAY][2:0]   >= 3'd7;
    dateWrap = regFile[IDX_DATE][5:0]  >= dateLimit;
    monWrap  = regFile[IDX_MONTH][4:0] >= 5'h12;
    yearWrap = regFile[IDX_YEAR]       >= 8'h99;

    nextVal[IDX_CTRL]  = regFile[IDX_CTRL];
    nextVal[IDX_SEC]   = {regFile[IDX_SEC][7], secWrap ? 7'h00 : secInc[6:0]};
    nextVal[IDX_MIN]   = {1'b0, minWrap ? 7'h00 : minInc[6:0]};
    nextVal[IDX_HOUR]  = {regFile[IDX_HOUR][7], 1'b0, hourWrap ? 6'h00 : hourInc[5:0]};
    nextVal[IDX_DAY]   = {1'b0, regFile[IDX_DAY][6], 3'b0,
                          dayWrap ? 3'd1 : regFile[IDX_DAY][2:0] + 3'd1};
    nextVal[IDX_DATE]  = {2'b0, dateWrap ? 6'h01 : dateInc[5:0]};
    nextVal[IDX_MONTH] = {3'b0, monWrap ? 5'h01 : monInc[4:0]};
    nextVal[IDX_YEAR]  = yearWrap ? 8'h00 : yearInc;

    // carry chain: a written register neither takes nor passes a carry
    advEn[IDX_CTRL]  = 1'b0;
    advEn[IDX_SEC]   = strb.tickGo && !strb.wrSel[IDX_SEC];
    advEn[IDX_MIN]   = advEn[IDX_SEC] && secWrap && !strb.wrSel[IDX_MIN];
    advEn[IDX_HOUR]  = advEn[IDX_MIN] && minWrap && !strb.wrSel[IDX_HOUR];
    advEn[IDX_DAY]   = advEn[IDX_HOUR] && hourWrap && !strb.wrSel[IDX_DAY];
    advEn[IDX_DATE]  = advEn[IDX_HOUR] && hourWrap && !strb.wrSel[IDX_DATE];
    advEn[IDX_MONTH] = advEn[IDX_DATE] && dateWrap && !strb.wrSel[IDX_MONTH];
    advEn[IDX_YEAR]  = advEn[IDX_MONTH] && monWrap && !strb.wrSel[IDX_YEAR];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < REG_NUM; k++) regFile[k] <= resetVal(IDX_W'(k));
    end else begin
      for (int k = 0; k < REG_NUM; k++) begin
        if (strb.wrSel[k])  regFile[k] <= wrData & fieldMask(IDX_W'(k));
        else if (advEn[k])  regFile[k] <= nextVal[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= 8'h00;
      rdIdxQ <= '0;
    end else if (strb.rdReq) begin
      rdData <= strb.rdHit ? regFile[strb.rdIdx] : 8'h00;
      rdIdxQ <= strb.rdIdx;
    end
  end

  assign ctrlByte = regFile[IDX_CTRL];
  assign stopBit  = regFile[IDX_SEC][7];
  assign kickBit  = regFile[IDX_HOUR][7];
  assign testBit  = regFile[IDX_DAY][6];

  logic [55:0] timeWord;
  assign timeWord = regFile[REG_NUM-1:1];

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (regFile[IDX_SEC][7] && strb.wrSel == '0) |=> $stable(timeWord)); // R4

  AST_SEC_ROLLOVER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tickGo && !strb.wrSel[IDX_SEC] && regFile[IDX_SEC][6:0] == 7'h59)
    |=> (regFile[IDX_SEC][6:0] == 7'h00)); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSel[IDX_MIN] |=> (regFile[IDX_MIN] == ($past(wrData) & 8'h7F))); // R9

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~fieldMask(rdIdxQ)) == 8'h00); // R3
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 11'h7F8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              stopOut,
  output logic              kickStart,
  output logic              freqTest,
  output logic [4:0]        calValue,
  output logic              calSign,
  output logic              ctlRead,
  output logic              ctlWrite
);
  tkStrobe_t  strb;
  logic [7:0] ctrlByte;

  tk_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .secTick(secTick), .stopBit(stopOut), .strb(strb)
  );

  tk_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .ctrlByte(ctrlByte), .stopBit(stopOut), .kickBit(kickStart), .testBit(freqTest)
  );

  assign calValue = ctrlByte[4:0];
  assign calSign  = ctrlByte[5];
  assign ctlRead  = ctrlByte[6];
  assign ctlWrite = ctrlByte[7];
endmodule

// File: tb/test_bcd_timekeeper.sv
module test_bcd_timekeeper;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [10:0] BASE = 11'h7F8;

  logic clk = 0, rstN = 0, secTick = 0, wrEn = 0, rdEn = 0;
  logic [10:0] addr = '0;
  logic [7:0] wrData = '0, rdData;
  logic stopOut, kickStart, freqTest, calSign, ctlRead, ctlWrite;
  logic [4:0] calValue;

  int vecCnt = 0, errCnt = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_timekeeper i_bcd_timekeeper (
    .clk(clk), .rstN(rstN), .secTick(secTick), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .stopOut(stopOut),
    .kickStart(kickStart), .freqTest(freqTest), .calValue(calValue),
    .calSign(calSign), .ctlRead(ctlRead), .ctlWrite(ctlWrite)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vecCnt++;
    if (got !== exp) begin
      errCnt++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // monitor: a read sampled at a rising edge is compared at the next falling edge
  initial forever begin
    @(posedge clk);
    if (rdEn) begin
      @(negedge clk);
      if (expQ.size() == 0) check("R2 unexpected read", rdData, 8'hxx);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic readReg(input logic [10:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    addr = a; rdEn = 1;
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic writeReg(input logic [10:0] a, input logic [7:0] d, input logic tk);
    addr = a; wrData = d; wrEn = 1; secTick = tk;
    @(negedge clk);
    wrEn = 0; secTick = 0;
  endtask

  task automatic doTick();
    secTick = 1;
    @(negedge clk);
    secTick = 0;
  endtask

  task automatic setTime(input logic [7:0] s, m, h, dw, dt, mo, y);
    writeReg(BASE + 11'd1, s, 0);  writeReg(BASE + 11'd2, m, 0);
    writeReg(BASE + 11'd3, h, 0);  writeReg(BASE + 11'd4, dw, 0);
    writeReg(BASE + 11'd5, dt, 0); writeReg(BASE + 11'd6, mo, 0);
    writeReg(BASE + 11'd7, y, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: got timeout expected completion (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 stopOut", {7'b0, stopOut}, 8'h01);
    readReg(BASE + 11'd0, 8'h00, "R1 control");
    readReg(BASE + 11'd1, 8'h80, "R1 seconds");
    readReg(BASE + 11'd2, 8'h00, "R1 minutes");
    readReg(BASE + 11'd3, 8'h00, "R1 hours");
    readReg(BASE + 11'd4, 8'h01, "R1 day");
    readReg(BASE + 11'd5, 8'h01, "R1 date");
    readReg(BASE + 11'd6, 8'h01, "R1 month");
    readReg(BASE + 11'd7, 8'h00, "R1 year");
    // R4 halted ticks ignored
    doTick(); doTick();
    readReg(BASE + 11'd1, 8'h80, "R4 halted");
    // R10 halt bit cleared, R4 tick advances
    writeReg(BASE + 11'd1, 8'h00, 0);
    check("R10 stopOut cleared", {7'b0, stopOut}, 8'h00);
    doTick();
    readReg(BASE + 11'd1, 8'h01, "R4 advance");
    writeReg(BASE + 11'd1, 8'h09, 0); doTick();
    readReg(BASE + 11'd1, 8'h10, "R4 bcd digit carry");
    // R5 R6 R7 full rollover
    setTime(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    doTick();
    readReg(BASE + 11'd1, 8'h00, "R5 sec wrap");
    readReg(BASE + 11'd2, 8'h00, "R5 min wrap");
    readReg(BASE + 11'd3, 8'h00, "R5 hour wrap");
    readReg(BASE + 11'd4, 8'h01, "R6 day wrap");
    readReg(BASE + 11'd5, 8'h01, "R7 date wrap");
    readReg(BASE + 11'd6, 8'h01, "R7 month wrap");
    readReg(BASE + 11'd7, 8'h00, "R7 year wrap");
    // R6 mid-week advance, R7 30-day month
    setTime(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23);
    doTick();
    readReg(BASE + 11'd4, 8'h04, "R6 day advance");
    readReg(BASE + 11'd5, 8'h01, "R7 april end");
    readReg(BASE + 11'd6, 8'h05, "R7 month carry");
    readReg(BASE + 11'd7, 8'h23, "R7 year held");
    // R7 31-day month no early wrap
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h23);
    doTick();
    readReg(BASE + 11'd5, 8'h31, "R7 may 31");
    // R8 leap handling
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    doTick();
    readReg(BASE + 11'd5, 8'h29, "R8 leap 24 feb 29");
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    doTick();
    readReg(BASE + 11'd5, 8'h01, "R8 leap 24 feb end");
    readReg(BASE + 11'd6, 8'h03, "R8 leap 24 march");
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    doTick();
    readReg(BASE + 11'd5, 8'h01, "R8 common 23 feb end");
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    doTick();
    readReg(BASE + 11'd5, 8'h29, "R8 leap 00");
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
    doTick();
    readReg(BASE + 11'd5, 8'h01, "R8 common 10");
    // R9 write coincident with tick
    setTime(8'h59, 8'h10, 8'h05, 8'h02, 8'h15, 8'h06, 8'h40);
    writeReg(BASE + 11'd2, 8'h30, 1);
    readReg(BASE + 11'd1, 8'h00, "R9 sec still advances");
    readReg(BASE + 11'd2, 8'h30, "R9 write wins minutes");
    writeReg(BASE + 11'd1, 8'h59, 0);
    writeReg(BASE + 11'd1, 8'h20, 1);
    readReg(BASE + 11'd1, 8'h20, "R9 write wins seconds");
    readReg(BASE + 11'd2, 8'h30, "R9 no carry out");
    // R2 foreign addresses
    readReg(11'h000, 8'h00, "R2 foreign read");
    writeReg(11'h7F1, 8'h45, 0);
    writeReg(11'h3FA, 8'h11, 0);
    readReg(BASE + 11'd1, 8'h20, "R2 foreign write seconds");
    readReg(BASE + 11'd2, 8'h30, "R2 foreign write minutes");
    // R3 reserved bits, R10 control outputs
    writeReg(BASE + 11'd1, 8'h80, 0);
    writeReg(BASE + 11'd2, 8'hFF, 0);
    writeReg(BASE + 11'd3, 8'hFF, 0);
    writeReg(BASE + 11'd4, 8'hFF, 0);
    writeReg(BASE + 11'd5, 8'hFF, 0);
    writeReg(BASE + 11'd6, 8'hFF, 0);
    writeReg(BASE + 11'd0, 8'hE5, 0);
    check("R10 calValue", {3'b0, calValue}, 8'h05);
    check("R10 flags", {4'b0, ctlWrite, ctlRead, calSign, stopOut}, 8'h0F);
    check("R10 kick/test", {6'b0, kickStart, freqTest}, 8'h03);
    readReg(BASE + 11'd2, 8'h7F, "R3 minutes");
    readReg(BASE + 11'd3, 8'hBF, "R3 hours");
    readReg(BASE + 11'd4, 8'h47, "R3 day");
    readReg(BASE + 11'd5, 8'h3F, "R3 date");
    readReg(BASE + 11'd6, 8'h1F, "R3 month");
    readReg(BASE + 11'd0, 8'hE5, "R10 control readback");
    writeReg(BASE + 11'd0, 8'h1A, 0);
    check("R10 calValue 2", {3'b0, calValue}, 8'h1A);
    check("R10 flags 2", {4'b0, ctlWrite, ctlRead, calSign, 1'b0}, 8'h00);
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) check("R2 pending reads", 8'(expQ.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule